// File: doc/BRIEF.md
# Conditional Branch Evaluator

This unit resolves a relative branch for a processor front end. In one step it looks at the branch opcode, a marker that says whether a long-form prefix byte came before that opcode, and the four condition flags: negative (N), zero (Z), overflow (V) and carry (C). From these it decides whether the branch is taken. It also forms the next program counter from the address of the following instruction and a signed displacement, and it reports how many bytes the instruction occupies and how many cycles it costs.

The branch condition comes from the low four bits of the opcode. Those sixteen codes cover the always and never forms plus fourteen flag relations, both unsigned and signed. The long form widens the displacement from 8 to 16 bits and makes the instruction longer. Its cycle cost also depends on whether the branch is taken. Fetching the displacement bytes and detecting the prefix are done upstream. The result is registered, so all outputs describe the inputs that were presented one clock earlier.

Top module: `bcc_branch_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is cleared to zero in that cycle.
- R2: Outputs are registered. The values presented at one rising edge show up at the outputs right after that edge and hold until the next edge.
- R3: Taken is decided by the opcode's low nibble as follows. 0: always. 1: never. 2: C=0 and Z=0. 3: C=1 or Z=1. 4: C=0. 5: C=1. 6: Z=0. 7: Z=1. 8: V=0. 9: V=1. A: N=0. B: N=1. C: N equals V. D: N differs from V. E: Z=0 and N equals V. F: Z=1 or N differs from V.
- R4: Opcode 0x20 is always taken and opcode 0x21 is never taken, whatever the flag values.
- R5: A taken short branch goes to the next-instruction address plus the sign-extended low 8 bits of `ofs_i`, modulo 2^16. Bits 15:8 of `ofs_i` have no effect in this case.
- R6: A taken long branch goes to the next-instruction address plus the full 16-bit `ofs_i` taken as two's complement, modulo 2^16.
- R7: When no branch is taken, `pc_o` equals the next-instruction address.
- R8: A short branch reports a length of 2 and a cost of 3 cycles, whether taken or not.
- R9: A long branch reports a length of 4, with a cost of 6 cycles when taken and 5 when not taken.
- R10: An opcode whose upper nibble is not 2 is not a branch. It gives `is_branch_o`=0, `taken_o`=0, `pc_o` equal to the next-instruction address, and length and cycles of 0. A branch opcode gives `is_branch_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 8 | Branch opcode byte |
| long_i | input | 1 | High when a long-form prefix preceded the opcode |
| n_i | input | 1 | Negative flag |
| z_i | input | 1 | Zero flag |
| v_i | input | 1 | Overflow flag |
| c_i | input | 1 | Carry flag |
| pc_next_i | input | 16 | Address of the following instruction |
| ofs_i | input | 16 | Displacement; only the low 8 bits count in short form |
| is_branch_o | output | 1 | Opcode lies in the branch range |
| taken_o | output | 1 | Branch is taken |
| pc_o | output | 16 | Next program counter |
| len_o | output | 3 | Instruction length in bytes |
| cyc_o | output | 3 | Cycle count |

## Verification
Every one of the sixteen condition codes is run with one flag setting that makes it taken or one that makes it not taken. For the paired relations, the setting is chosen so that one flag decides the outcome. This catches a swapped nibble, an inverted flag, or a signed relation that was mixed up with an unsigned one. The same codes are run in both short and long form with positive and negative displacements, which separates the 8-bit and 16-bit sign extension. Further vectors cover short offsets whose high byte is non-zero, target arithmetic that wraps past the top and the bottom of the 16-bit space, and opcodes outside the branch range.

// File: rtl/bcc_pkg.sv
// Package: shared types for the branch evaluator.
// Assumes: the condition selector is the low opcode nibble.
package bcc_pkg;

    // Condition selector; the numeric value equals the opcode low nibble.
    typedef enum logic [3:0] {
        COND_ALWAYS = 4'h0,
        COND_NEVER  = 4'h1,
        COND_HI     = 4'h2,
        COND_LS     = 4'h3,
        COND_CCLR   = 4'h4,
        COND_CSET   = 4'h5,
        COND_NE     = 4'h6,
        COND_EQ     = 4'h7,
        COND_VCLR   = 4'h8,
        COND_VSET   = 4'h9,
        COND_PL     = 4'hA,
        COND_MI     = 4'hB,
        COND_GE     = 4'hC,
        COND_LT     = 4'hD,
        COND_GT     = 4'hE,
        COND_LE     = 4'hF
    } cond_e;

    // Condition flags as seen by the evaluator.
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    // Upper opcode nibble that marks the branch family.
    localparam logic [3:0] BRANCH_GROUP = 4'h2;

endpackage

// File: rtl/bcc_cond_eval.sv
// Module: bcc_cond_eval
// Decides whether a branch is taken from its condition selector and the flags.
// Assumes: purely combinational; the caller qualifies the result with the
// branch-range decode.
module bcc_cond_eval
    import bcc_pkg::*;
(
    input  cond_e  sel_i,
    input  flags_t fl_i,
    output logic   take_o
);

    logic sgn_lt;

    // Signed less-than holds when the sign and overflow flags disagree.
    always_comb sgn_lt = fl_i.n ^ fl_i.v;

    // Selects the relation named by the condition code.
    always_comb begin
        unique case (sel_i)
            COND_ALWAYS: take_o = 1'b1;
            COND_NEVER:  take_o = 1'b0;
            COND_HI:     take_o = ~fl_i.c & ~fl_i.z;
            COND_LS:     take_o = fl_i.c | fl_i.z;
            COND_CCLR:   take_o = ~fl_i.c;
            COND_CSET:   take_o = fl_i.c;
            COND_NE:     take_o = ~fl_i.z;
            COND_EQ:     take_o = fl_i.z;
            COND_VCLR:   take_o = ~fl_i.v;
            COND_VSET:   take_o = fl_i.v;
            COND_PL:     take_o = ~fl_i.n;
            COND_MI:     take_o = fl_i.n;
            COND_GE:     take_o = ~sgn_lt;
            COND_LT:     take_o = sgn_lt;
            COND_GT:     take_o = ~fl_i.z & ~sgn_lt;
            COND_LE:     take_o = fl_i.z | sgn_lt;
            default:     take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcc_target.sv
// Module: bcc_target
// Adds a signed displacement to the next-instruction address.
// Assumes: the short form uses the low SHORT_W bits sign-extended, the long
// form uses all PC_W bits, and the sum wraps modulo 2^PC_W.
module bcc_target #(
    parameter int PC_W    = 16,
    parameter int SHORT_W = 8
) (
    input  logic            is_long_i,
    input  logic [PC_W-1:0] next_i,
    input  logic [PC_W-1:0] ofs_i,
    output logic [PC_W-1:0] target_o
);

    localparam int EXT_W = PC_W - SHORT_W;

    logic [PC_W-1:0] short_ext;
    logic [PC_W-1:0] disp;

    // Sign-extends the short displacement; the parameter picks whether any
    // extension bits are needed.
    generate
        if (EXT_W > 0) begin : g_ext
            always_comb short_ext = {{EXT_W{ofs_i[SHORT_W-1]}}, ofs_i[SHORT_W-1:0]};
        end else begin : g_noext
            always_comb short_ext = ofs_i;
        end
    endgenerate

    // Picks the displacement width for the form in use.
    always_comb disp = is_long_i ? ofs_i : short_ext;

    // Forms the wrapped branch target.
    always_comb target_o = next_i + disp;

endmodule

// File: rtl/bcc_cost.sv
// Module: bcc_cost
// Reports the byte length and cycle cost of a branch instruction.
// Assumes: non-branch opcodes report zero for both values.
module bcc_cost #(
    parameter int LEN_W       = 3,
    parameter int CYC_W       = 3,
    parameter int SHORT_LEN   = 2,
    parameter int LONG_LEN    = 4,
    parameter int SHORT_CYC   = 3,
    parameter int LONG_CYC_NT = 5,
    parameter int LONG_CYC_T  = 6
) (
    input  logic             is_branch_i,
    input  logic             is_long_i,
    input  logic             take_i,
    output logic [LEN_W-1:0] len_o,
    output logic [CYC_W-1:0] cyc_o
);

    localparam logic [LEN_W-1:0] L_SHORT = LEN_W'(SHORT_LEN);
    localparam logic [LEN_W-1:0] L_LONG  = LEN_W'(LONG_LEN);
    localparam logic [CYC_W-1:0] C_SHORT = CYC_W'(SHORT_CYC);
    localparam logic [CYC_W-1:0] C_LNT   = CYC_W'(LONG_CYC_NT);
    localparam logic [CYC_W-1:0] C_LT    = CYC_W'(LONG_CYC_T);

    // Looks up the length and the cost for the form and the outcome.
    always_comb begin
        if (!is_branch_i) begin
            len_o = '0;
            cyc_o = '0;
        end else if (is_long_i) begin
            len_o = L_LONG;
            cyc_o = take_i ? C_LT : C_LNT;
        end else begin
            len_o = L_SHORT;
            cyc_o = C_SHORT;
        end
    end

endmodule

// File: rtl/bcc_branch_unit.sv
// Module: bcc_branch_unit (top)
// Decides a relative branch, forms the next PC and reports its cost, with
// all results registered one clock after the inputs.
// Assumes: prefix detection and displacement fetch are done upstream; the
// flags are only read and never changed here.
module bcc_branch_unit
    import bcc_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int SHORT_W = 8,
    parameter int LEN_W   = 3,
    parameter int CYC_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       op_i,
    input  logic             long_i,
    input  logic             n_i,
    input  logic             z_i,
    input  logic             v_i,
    input  logic             c_i,
    input  logic [PC_W-1:0]  pc_next_i,
    input  logic [PC_W-1:0]  ofs_i,
    output logic             is_branch_o,
    output logic             taken_o,
    output logic [PC_W-1:0]  pc_o,
    output logic [LEN_W-1:0] len_o,
    output logic [CYC_W-1:0] cyc_o
);

    logic             in_range;
    logic             cond_hit;
    logic             take;
    flags_t           flags;
    cond_e            sel;
    logic [PC_W-1:0]  target;
    logic [PC_W-1:0]  pc_nxt;
    logic [LEN_W-1:0] len_nxt;
    logic [CYC_W-1:0] cyc_nxt;

    // Decodes the branch family and the condition selector from the opcode.
    always_comb begin
        in_range = (op_i[7:4] == BRANCH_GROUP);
        sel      = cond_e'(op_i[3:0]);
        flags    = '{n: n_i, z: z_i, v: v_i, c: c_i};
    end

    bcc_cond_eval u_cond (
        .sel_i  (sel),
        .fl_i   (flags),
        .take_o (cond_hit)
    );

    // Qualifies the condition with the branch-range decode.
    always_comb take = in_range & cond_hit;

    bcc_target #(
        .PC_W    (PC_W),
        .SHORT_W (SHORT_W)
    ) u_target (
        .is_long_i (long_i),
        .next_i    (pc_next_i),
        .ofs_i     (ofs_i),
        .target_o  (target)
    );

    // Chooses between the branch target and the fall-through address.
    always_comb pc_nxt = take ? target : pc_next_i;

    bcc_cost #(
        .LEN_W (LEN_W),
        .CYC_W (CYC_W)
    ) u_cost (
        .is_branch_i (in_range),
        .is_long_i   (long_i),
        .take_i      (take),
        .len_o       (len_nxt),
        .cyc_o       (cyc_nxt)
    );

    // Registers the results; a synchronous reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_branch_o <= 1'b0;
            taken_o     <= 1'b0;
            pc_o        <= '0;
            len_o       <= '0;
            cyc_o       <= '0;
        end else begin
            is_branch_o <= in_range;
            taken_o     <= take;
            pc_o        <= pc_nxt;
            len_o       <= len_nxt;
            cyc_o       <= cyc_nxt;
        end
    end

endmodule

// File: rtl/bcc_branch_unit_chk.sv
// Module: bcc_branch_unit_chk
// Checker for the port-level timing and the cost rules of bcc_branch_unit.
// Assumes: it is bound into every instance of the top module.
module bcc_branch_unit_chk #(
    parameter int PC_W  = 16,
    parameter int LEN_W = 3,
    parameter int CYC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       op_i,
    input logic             long_i,
    input logic [PC_W-1:0]  pc_next_i,
    input logic             is_branch_o,
    input logic             taken_o,
    input logic [PC_W-1:0]  pc_o,
    input logic [LEN_W-1:0] len_o,
    input logic [CYC_W-1:0] cyc_o
);

    // R10: a non-branch opcode reports nothing taken and no cost.
    a_r10_non_branch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !is_branch_o |-> (!taken_o && len_o == '0 && cyc_o == '0));

    // R8: the short form always costs three cycles.
    a_r8_short_cost: assert property (@(posedge clk) disable iff (!rst_n)
        (is_branch_o && len_o == LEN_W'(2)) |-> cyc_o == CYC_W'(3));

    // R9: the long form cost follows the outcome.
    a_r9_long_cost: assert property (@(posedge clk) disable iff (!rst_n)
        (is_branch_o && len_o == LEN_W'(4)) |-> cyc_o == (taken_o ? CYC_W'(6) : CYC_W'(5)));

    // R7: the fall-through address appears when nothing is taken.
    a_r7_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !taken_o) |-> pc_o == $past(pc_next_i));

    // R4: the always form is taken one clock later.
    a_r4_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 8'h20) |-> taken_o);

    // R4: the never form is never taken.
    a_r4_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 8'h21) |-> !taken_o);

    // R2: the reported length follows the form presented one clock earlier.
    a_r2_len_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && is_branch_o) |-> len_o == ($past(long_i) ? LEN_W'(4) : LEN_W'(2)));

endmodule

bind bcc_branch_unit bcc_branch_unit_chk #(
    .PC_W  (PC_W),
    .LEN_W (LEN_W),
    .CYC_W (CYC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .long_i      (long_i),
    .pc_next_i   (pc_next_i),
    .is_branch_o (is_branch_o),
    .taken_o     (taken_o),
    .pc_o        (pc_o),
    .len_o       (len_o),
    .cyc_o       (cyc_o)
);

// File: tb/bcc_branch_unit_bench.sv
module bcc_branch_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_i = 8'h00;
    logic        long_i = 1'b0;
    logic        n_i = 1'b0, z_i = 1'b0, v_i = 1'b0, c_i = 1'b0;
    logic [15:0] pc_next_i = '0;
    logic [15:0] ofs_i = '0;
    logic        is_branch_o, taken_o;
    logic [15:0] pc_o;
    logic [2:0]  len_o, cyc_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcc_branch_unit u_bcc_branch_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .long_i(long_i),
        .n_i(n_i), .z_i(z_i), .v_i(v_i), .c_i(c_i),
        .pc_next_i(pc_next_i), .ofs_i(ofs_i),
        .is_branch_o(is_branch_o), .taken_o(taken_o), .pc_o(pc_o),
        .len_o(len_o), .cyc_o(cyc_o)
    );

    // Each entry: opcode, long flag, flags {N,Z,V,C}, next address, offset, expected taken.
    localparam logic [45:0] VEC [NVEC] = '{
        {8'h20, 1'b0, 4'b0000, 16'h1000, 16'h0010, 1'b1},
        {8'h21, 1'b0, 4'b1111, 16'h1000, 16'h0010, 1'b0},
        {8'h22, 1'b0, 4'b0000, 16'h2000, 16'h00F0, 1'b1},
        {8'h22, 1'b0, 4'b0100, 16'h2000, 16'h00F0, 1'b0},
        {8'h23, 1'b0, 4'b0001, 16'h3000, 16'h0005, 1'b1},
        {8'h24, 1'b0, 4'b0001, 16'h3000, 16'h0005, 1'b0},
        {8'h25, 1'b1, 4'b0001, 16'h4000, 16'h1234, 1'b1},
        {8'h26, 1'b0, 4'b0000, 16'h0100, 16'h0080, 1'b1},
        {8'h27, 1'b1, 4'b0100, 16'h0100, 16'hFF00, 1'b1},
        {8'h28, 1'b0, 4'b0010, 16'h5000, 16'h0001, 1'b0},
        {8'h29, 1'b0, 4'b0010, 16'h5000, 16'h0001, 1'b1},
        {8'h2A, 1'b0, 4'b1000, 16'h6000, 16'h007F, 1'b0},
        {8'h2B, 1'b1, 4'b1000, 16'h6000, 16'h8000, 1'b1},
        {8'h2C, 1'b0, 4'b1010, 16'h7000, 16'h0040, 1'b1},
        {8'h2D, 1'b0, 4'b1000, 16'h7000, 16'h00C0, 1'b1},
        {8'h2E, 1'b0, 4'b0100, 16'h8000, 16'h0010, 1'b0},
        {8'h2E, 1'b1, 4'b0000, 16'h8000, 16'h0010, 1'b1},
        {8'h2F, 1'b0, 4'b0010, 16'h9000, 16'h00FE, 1'b1},
        {8'h2C, 1'b1, 4'b1000, 16'h9000, 16'h0100, 1'b0},
        {8'h24, 1'b1, 4'b0000, 16'hA000, 16'hF000, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] op, input logic lg, input logic [3:0] f,
                         input logic [15:0] nx, input logic [15:0] of);
        @(negedge clk);
        op_i = op; long_i = lg; {n_i, z_i, v_i, c_i} = f;
        pc_next_i = nx; ofs_i = of;
        @(posedge clk);
        #1;
    endtask

    // Spec model of the target, length and cost (R5 to R10).
    function automatic logic [15:0] exp_pc(input logic tk, input logic lg,
                                           input logic [15:0] nx, input logic [15:0] of);
        if (!tk) return nx;
        if (lg)  return nx + of;
        return nx + {{8{of[7]}}, of[7:0]};
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        // R1: reset clears outputs, even with a taken branch applied.
        op_i = 8'h20; pc_next_i = 16'h1234; ofs_i = 16'h0004;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset taken", {31'd0, taken_o}, 32'd0);
        check("R1 reset pc", {16'd0, pc_o}, 32'd0);
        check("R1 reset len/cyc", {26'd0, len_o, cyc_o}, 32'd0);
        check("R1 reset is_branch", {31'd0, is_branch_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 R8 R9: table walk over the condition codes and both forms.
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0]  op;
            logic        lg, tk;
            logic [3:0]  f;
            logic [15:0] nx, of;
            {op, lg, f, nx, of, tk} = VEC[i];
            drive(op, lg, f, nx, of);
            check($sformatf("R3 taken vec%0d", i), {31'd0, taken_o}, {31'd0, tk});
            check($sformatf("R5/R6/R7 pc vec%0d", i), {16'd0, pc_o}, {16'd0, exp_pc(tk, lg, nx, of)});
            check($sformatf("R8/R9 len vec%0d", i), {29'd0, len_o}, lg ? 32'd4 : 32'd2);
            check($sformatf("R8/R9 cyc vec%0d", i), {29'd0, cyc_o},
                  lg ? (tk ? 32'd6 : 32'd5) : 32'd3);
            check($sformatf("R10 is_branch vec%0d", i), {31'd0, is_branch_o}, 32'd1);
        end

        // R4: always/never ignore every flag combination.
        for (int f = 0; f < 16; f++) begin
            drive(8'h20, 1'b0, f[3:0], 16'h0200, 16'h0002);
            check("R4 always", {31'd0, taken_o}, 32'd1);
            drive(8'h21, 1'b1, f[3:0], 16'h0200, 16'h0002);
            check("R4 never", {31'd0, taken_o}, 32'd0);
        end

        // R5: short offset ignores bits 15:8 and wraps below zero.
        drive(8'h20, 1'b0, 4'b0000, 16'h1000, 16'hAB80);
        check("R5 upper byte ignored", {16'd0, pc_o}, 32'h0F80);
        drive(8'h20, 1'b0, 4'b0000, 16'h0005, 16'h0080);
        check("R5 wrap down", {16'd0, pc_o}, 32'hFF85);

        // R6: long offset wraps past the top.
        drive(8'h20, 1'b1, 4'b0000, 16'hFFF0, 16'h0020);
        check("R6 wrap up", {16'd0, pc_o}, 32'h0010);
        check("R9 long taken cyc", {29'd0, cyc_o}, 32'd6);

        // R10: out-of-range opcodes.
        drive(8'h86, 1'b0, 4'b1111, 16'h3456, 16'h0040);
        check("R10 not branch", {31'd0, is_branch_o}, 32'd0);
        check("R10 not taken", {31'd0, taken_o}, 32'd0);
        check("R10 pc", {16'd0, pc_o}, 32'h3456);
        check("R10 len/cyc", {26'd0, len_o, cyc_o}, 32'd0);
        drive(8'h30, 1'b1, 4'b0000, 16'h0777, 16'h0040);
        check("R10 long not branch", {26'd0, len_o, cyc_o}, 32'd0);
        check("R10 long pc", {16'd0, pc_o}, 32'h0777);

        // R2: a new input does not show before the next edge.
        drive(8'h20, 1'b0, 4'b0000, 16'h4000, 16'h0010);
        @(negedge clk);
        op_i = 8'h21; pc_next_i = 16'h5000;
        #1;
        check("R2 held before edge", {16'd0, pc_o}, 32'h4010);
        @(posedge clk);
        #1;
        check("R2 updated after edge", {16'd0, pc_o}, 32'h5000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule